// File: doc/BRIEF.md
# Gated 16-bit Event Counter

This block is a 16-bit up-counter that either runs on every clock or advances only while a chosen gate signal is at a chosen level. The gate comes from one of four places: an external gate pin, a one-cycle pulse from an internal 8-bit period timer, or one of two comparator result inputs. Each comparator input can be passed through raw or resynchronized to the counter clock. The pin always goes through a two-flop synchronizer.

Software reaches the block over a small 8-bit register bus. The 16-bit value is accessed as two bytes. In pair mode, a low-byte read snapshots the high byte into a holding register, and a low-byte write loads the holding register into the upper half at the same moment. This keeps 16-bit reads and writes coherent while the counter runs. A wrap from FFFFh to 0000h sets a sticky overflow flag.

Top module: `gated_counter`

## Requirements
- R1: With gate_en (ctrl bit 0) clear, the counter advances by one on every clock, whatever the gate inputs are.
- R2: With gate_en set, the counter advances only in cycles where the selected gate level equals the polarity bit (ctrl bit 1). In every other cycle it holds its value.
- R3: Ctrl bits 3:2 pick the gate: 0 selects the gate pin, 1 the period-timer pulse, 2 comparator 1 (cmp_i[0]) and 3 comparator 2 (cmp_i[1]).
- R4: The period timer counts up every clock until it equals the period register (address 3). On the next clock it returns to 0 and drives a pulse that is high for exactly one cycle. With period P and polarity 1, the counter advances once every P+1 cycles. A write to the period register restarts the timer at 0. The timer value reads at address 5.
- R5: Ctrl bit 4 (comparator 1) and bit 5 (comparator 2) select a two-flop resynchronizer when set. When clear, the raw input gates the very next clock edge. The gate pin always passes through two flops.
- R6: A wrap from FFFFh to 0000h sets the overflow flag (status, address 4, bit 0). The flag stays set until a status write with bit 0 high clears it. A write with bit 0 low has no effect, and a new wrap in the same cycle wins over the clear.
- R7: In pair mode (ctrl bit 6 set), a low-byte read (address 1, rd_i high) captures the live high byte into a holding register. High-byte reads (address 2) then return that holding register.
- R8: In pair mode, a high-byte write fills only the holding register and leaves the counter unchanged. A low-byte write loads {holding, data} into the counter.
- R9: With pair mode clear, the high byte reads live, a high-byte write replaces only the upper byte, and a low-byte write replaces only the lower byte.
- R10: A bus write to either counter byte takes effect in place of an increment in the same cycle, so the written value is seen unchanged after that edge.
- R11: After reset, the counter, period timer, period register, holding register, flag and ctrl are all zero.
- R12: Register map: 0 ctrl (bits 6:0), 1 counter low, 2 counter high, 3 period, 4 status, 5 period-timer value (read only). Reads are combinational from addr_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counter clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| gate_pin_i | input | 1 | External gate, asynchronous |
| cmp_i | input | 2 | Comparator results, bit 0 = comparator 1 |
| addr_i | input | 3 | Register address |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (drives the pair-mode snapshot) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The assertions assume that wr_i and rd_i are never high in the same cycle. They also assume that the gate pin and comparator inputs change only between clock edges, so the synchronizer outputs can be predicted. The bench drives every input on the falling edge and issues one bus operation per cycle. It lets the gate inputs settle for three cycles before it starts each counted window, except in the latency tests, where the exact delay of the raw and resynchronized paths is the thing being measured.

// File: rtl/gcnt_pkg.sv
package gcnt_pkg;
  localparam int BUS_W   = 8;
  localparam int CNT_W   = 2 * BUS_W;
  localparam int PT_W    = 8;
  localparam int NUM_CMP = 2;
  localparam int ADDR_W  = 3;

  typedef enum logic [1:0] {
    SRC_PIN    = 2'd0,
    SRC_PERIOD = 2'd1,
    SRC_CMP1   = 2'd2,
    SRC_CMP2   = 2'd3
  } gate_src_e;

  typedef struct packed {
    logic                  pair_mode;
    logic [NUM_CMP-1:0]    cmp_sync;
    gate_src_e             src;
    logic                  pol;
    logic                  gate_en;
  } ctrl_t;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_LO   = 3'd1;
  localparam logic [ADDR_W-1:0] A_HI   = 3'd2;
  localparam logic [ADDR_W-1:0] A_PER  = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd4;
  localparam logic [ADDR_W-1:0] A_PTMR = 3'd5;
endpackage

// File: rtl/gcnt_sync.sv
module gcnt_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gcnt_period_timer.sv
module gcnt_period_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] period_i,
  output logic [W-1:0] tmr_o,
  output logic         pulse_o
);
  logic [W-1:0] tmr_q;
  logic         pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q   <= '0;
      pulse_q <= 1'b0;
    end else if (clr_i) begin
      tmr_q   <= '0;
      pulse_q <= 1'b0;
    end else if (tmr_q == period_i) begin
      tmr_q   <= '0;
      pulse_q <= 1'b1;
    end else begin
      tmr_q   <= tmr_q + 1'b1;
      pulse_q <= 1'b0;
    end
  end

  assign tmr_o   = tmr_q;
  assign pulse_o = pulse_q;

  // R4
  wrap_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && tmr_q == period_i) |=> (tmr_q == '0 && pulse_q));

  // R4
  pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_q && period_i != '0) |=> !pulse_q);
endmodule

// File: rtl/gcnt_gate_sel.sv
module gcnt_gate_sel
  import gcnt_pkg::*;
(
  input  ctrl_t              ctrl_i,
  input  logic               pin_s_i,
  input  logic               pulse_i,
  input  logic [NUM_CMP-1:0] cmp_g_i,
  output logic               cnt_en_o
);
  logic gate_lvl;

  always_comb begin
    unique case (ctrl_i.src)
      SRC_PIN:    gate_lvl = pin_s_i;
      SRC_PERIOD: gate_lvl = pulse_i;
      SRC_CMP1:   gate_lvl = cmp_g_i[0];
      default:    gate_lvl = cmp_g_i[1];
    endcase
  end

  assign cnt_en_o = !ctrl_i.gate_en || (gate_lvl == ctrl_i.pol);
endmodule

// File: rtl/gated_counter.sv
module gated_counter
  import gcnt_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               gate_pin_i,
  input  logic [NUM_CMP-1:0] cmp_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [BUS_W-1:0]   wdata_i,
  output logic [BUS_W-1:0]   rdata_o,
  output logic               ovf_o
);
  ctrl_t              ctrl_q;
  logic [PT_W-1:0]    period_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [BUS_W-1:0]   hold_q;
  logic               ovf_q;
  logic [PT_W-1:0]    ptmr;
  logic               pulse;
  logic               pin_s;
  logic [NUM_CMP-1:0] cmp_s, cmp_g;
  logic               cnt_en;

  logic wr_ctrl, wr_lo, wr_hi, wr_per, wr_stat, rd_lo, cnt_wr;
  assign wr_ctrl = wr_i && addr_i == A_CTRL;
  assign wr_lo   = wr_i && addr_i == A_LO;
  assign wr_hi   = wr_i && addr_i == A_HI;
  assign wr_per  = wr_i && addr_i == A_PER;
  assign wr_stat = wr_i && addr_i == A_STAT;
  assign rd_lo   = rd_i && addr_i == A_LO;
  assign cnt_wr  = wr_lo || (wr_hi && !ctrl_q.pair_mode);

  gcnt_sync #(.W(1)) u_pin_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(gate_pin_i), .q_o(pin_s)
  );

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    gcnt_sync #(.W(1)) u_cmp_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cmp_i[g]), .q_o(cmp_s[g])
    );
    assign cmp_g[g] = ctrl_q.cmp_sync[g] ? cmp_s[g] : cmp_i[g];
  end

  gcnt_period_timer #(.W(PT_W)) u_ptmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(wr_per),
    .period_i(period_q), .tmr_o(ptmr), .pulse_o(pulse)
  );

  gcnt_gate_sel u_gate (
    .ctrl_i(ctrl_q), .pin_s_i(pin_s), .pulse_i(pulse),
    .cmp_g_i(cmp_g), .cnt_en_o(cnt_en)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      period_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q   <= ctrl_t'(wdata_i[$bits(ctrl_t)-1:0]);
      if (wr_per)  period_q <= wdata_i[PT_W-1:0];
    end
  end

  // Holding register for coherent pair access
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          hold_q <= '0;
    else if (wr_hi && ctrl_q.pair_mode)   hold_q <= wdata_i;
    else if (rd_lo && ctrl_q.pair_mode)   hold_q <= cnt_q[CNT_W-1:BUS_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (wr_lo) begin
      cnt_q <= {ctrl_q.pair_mode ? hold_q : cnt_q[CNT_W-1:BUS_W], wdata_i};
    end else if (wr_hi && !ctrl_q.pair_mode) begin
      cnt_q <= {wdata_i, cnt_q[BUS_W-1:0]};
    end else if (cnt_en) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           ovf_q <= 1'b0;
    else if (cnt_en && !cnt_wr && &cnt_q)  ovf_q <= 1'b1;
    else if (wr_stat && wdata_i[0])        ovf_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL: rdata_o = BUS_W'(ctrl_q);
      A_LO:   rdata_o = cnt_q[BUS_W-1:0];
      A_HI:   rdata_o = ctrl_q.pair_mode ? hold_q : cnt_q[CNT_W-1:BUS_W];
      A_PER:  rdata_o = period_q;
      A_STAT: rdata_o = BUS_W'(ovf_q);
      A_PTMR: rdata_o = ptmr;
      default: rdata_o = '0;
    endcase
  end

  assign ovf_o = ovf_q;

  // R1
  free_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.gate_en && !cnt_wr) |=> cnt_q == $past(cnt_q) + 1'b1);

  // R2
  gate_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_en && !cnt_wr) |=> $stable(cnt_q));

  // R6
  ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en && !cnt_wr && &cnt_q) |=> ovf_q);

  // R6
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !(wr_stat && wdata_i[0])) |=> ovf_q);

  // R10
  wr_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo |=> cnt_q[BUS_W-1:0] == $past(wdata_i));

  // R8
  pair_hi_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hi && ctrl_q.pair_mode && !cnt_en) |=> $stable(cnt_q));
endmodule

// File: tb/gated_counter_test.sv
module gated_counter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin = 1'b0;
  logic [1:0] cmp = 2'b00;
  logic [2:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       ovf;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gated_counter uut (
    .clk_i(clk), .rst_ni(rst_n), .gate_pin_i(pin), .cmp_i(cmp),
    .addr_i(addr), .wr_i(wr_en), .rd_i(rd_en), .wdata_i(wdata),
    .rdata_o(rdata), .ovf_o(ovf)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=%0d cycles expected<50000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // {gate_en, pol, src[1:0], c1_sync, c2_sync, pin, cmp1, cmp2, counts}
  localparam logic [9:0] VEC [12] = '{
    10'b0_0_00_0_0_1_0_0_1,  // R1 free
    10'b0_1_00_0_0_0_1_1_1,  // R1 gate off ignores inputs
    10'b1_0_00_0_0_0_0_0_1,  // R2 pin 0 pol 0
    10'b1_0_00_0_0_1_0_0_0,  // R2 pin 1 pol 0
    10'b1_1_00_0_0_1_0_0_1,  // R2 pin 1 pol 1
    10'b1_1_00_0_0_0_1_1_0,  // R2 pin 0 pol 1
    10'b1_1_10_0_0_0_1_0_1,  // R3 cmp1 raw
    10'b1_1_10_1_0_1_0_1_0,  // R3 cmp1 sync low
    10'b1_0_11_0_1_1_1_0_1,  // R3 cmp2 sync low pol 0
    10'b1_1_11_0_0_1_1_0_0,  // R3 cmp2 raw low
    10'b1_1_11_0_1_0_0_1_1,  // R3 cmp2 sync high
    10'b1_0_10_0_0_0_1_0_0   // R3 cmp1 raw high pol 0
  };

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    rd(3'd1, v); chk(v, 8'h00, "R11 cnt lo");
    rd(3'd0, v); chk(v, 8'h00, "R11 ctrl");
    rd(3'd4, v); chk(v, 8'h00, "R11 flag");
    rd(3'd3, v); chk(v, 8'h00, "R11 period");
    rd(3'd2, v); chk(v, 8'h00, "R11 cnt hi");

    for (int i = 0; i < 12; i++) begin
      logic [9:0] e;
      e = VEC[i];
      pin = e[3]; cmp = {e[1], e[2]};
      wr(3'd0, {2'b00, e[4], e[5], e[7:6], e[8], e[9]});
      repeat (3) @(negedge clk);
      wr(3'd2, 8'h00); wr(3'd1, 8'h00);
      repeat (8) @(negedge clk);
      rd(3'd1, v); chk(v, e[0] ? 8'd8 : 8'd0, $sformatf("R2/R3 vector %0d", i));
    end

    // R5 raw comparator gates next edge
    cmp = 2'b00;
    wr(3'd0, 8'h0B); repeat (3) @(negedge clk);
    wr(3'd2, 8'h00); wr(3'd1, 8'h00);
    cmp = 2'b01; @(negedge clk);
    rd(3'd1, v); chk(v, 8'd1, "R5 raw latency");
    // R5 synchronized comparator: two flop delay
    cmp = 2'b00;
    wr(3'd0, 8'h1B); repeat (3) @(negedge clk);
    wr(3'd2, 8'h00); wr(3'd1, 8'h00);
    cmp = 2'b01; @(negedge clk);
    rd(3'd1, v); chk(v, 8'd0, "R5 sync latency early");
    @(negedge clk);
    rd(3'd1, v); chk(v, 8'd1, "R5 sync latency");

    // R4 period pulse, pol 1 then pol 0
    wr(3'd3, 8'h04); wr(3'd0, 8'h07); wr(3'd2, 8'h00); wr(3'd1, 8'h00);
    repeat (15) @(negedge clk);
    rd(3'd1, v); chk(v, 8'd3, "R4 one per period");
    wr(3'd3, 8'h04); wr(3'd0, 8'h05); wr(3'd2, 8'h00); wr(3'd1, 8'h00);
    repeat (15) @(negedge clk);
    rd(3'd1, v); chk(v, 8'd12, "R4 inverted pulse");
    wr(3'd3, 8'h9A);
    rd(3'd5, v); chk(v, 8'h00, "R4 timer restart");
    rd(3'd5, v); chk(v, 8'h01, "R4 timer step");
    rd(3'd3, v); chk(v, 8'h9A, "R12 period readback");

    // R6 overflow
    pin = 1'b0;
    wr(3'd0, 8'h03); repeat (3) @(negedge clk);
    wr(3'd2, 8'hFF); wr(3'd1, 8'hFF);
    rd(3'd4, v); chk(v, 8'h00, "R6 no flag while held");
    wr(3'd0, 8'h00);
    rd(3'd4, v); chk(v, 8'h00, "R6 flag before wrap");
    rd(3'd4, v); chk(v, 8'h01, "R6 flag after wrap");
    rd(3'd2, v); chk(v, 8'h00, "R6 wrapped hi");
    repeat (5) @(negedge clk);
    wr(3'd4, 8'h00);
    rd(3'd4, v); chk(v, 8'h01, "R6 sticky");
    wr(3'd4, 8'h01);
    rd(3'd4, v); chk(v, 8'h00, "R6 cleared");

    // R10 write beats increment
    wr(3'd1, 8'h40);
    rd(3'd1, v); chk(v, 8'h40, "R10 write priority");
    rd(3'd1, v); chk(v, 8'h41, "R10 resumes");

    // R7/R8/R9 byte access
    wr(3'd0, 8'h03);
    wr(3'd2, 8'h12); wr(3'd1, 8'h34);
    wr(3'd0, 8'h43);
    rd(3'd1, v); chk(v, 8'h34, "R7 lo read");
    wr(3'd0, 8'h03); wr(3'd2, 8'h56);
    wr(3'd0, 8'h43);
    rd(3'd2, v); chk(v, 8'h12, "R7 buffered hi");
    wr(3'd0, 8'h03);
    rd(3'd2, v); chk(v, 8'h56, "R9 live hi");
    wr(3'd0, 8'h43); wr(3'd2, 8'hAB); wr(3'd0, 8'h03);
    rd(3'd2, v); chk(v, 8'h56, "R8 hi write deferred");
    wr(3'd0, 8'h43); wr(3'd1, 8'hCD); wr(3'd0, 8'h03);
    rd(3'd2, v); chk(v, 8'hAB, "R8 pair write hi");
    rd(3'd1, v); chk(v, 8'hCD, "R8 pair write lo");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule